// File: doc/BRIEF.md
# MMC Command and Response Engine

This block drives the command line of an MMC card. Software loads a command into a small buffer through one byte-wide write port: the command index comes first, then the four bytes of the 32-bit argument, most significant byte first. It then picks the response options and pulses a start input. The engine sends the 48-bit command frame, which ends with a CRC7 that the engine computes itself. It then releases the line and waits for the card's start bit.

When a response arrives, the engine shifts in either a short (48-bit) or a long (136-bit) frame and stores it byte by byte in a receive FIFO. It raises a format status and a CRC status, and sets an end-of-response flag that serves as the interrupt request. If the card stays silent for too long, a timeout flag is set along with the end-of-response flag, so the engine cannot hang. Two level-held controls give a recovery path. One rewinds the FIFO read pointer so a response can be re-read. The other returns the command state machine to idle. One cycle of `clk` is one MMC bit period.

Top module: `mmc_cmd_engine`

## Requirements
- R1: Each `cmd_wr` while idle stores `cmd_wdata` in the command buffer. Slot 0 holds the index (bits 5:0 used), and slots 1 to 4 hold argument bits 31:24, 23:16, 15:8 and 7:0. After the fifth write the slot pointer wraps to 0, and a start also resets it to 0.
- R2: A `tx_start` while idle makes `cmd_oe` high for exactly 48 cycles, starting the next cycle. During those cycles `cmd_out` carries, MSB first: 0, 1, the 6-bit index, the 32-bit argument, the CRC7 of those first 40 bits (polynomial x^7+x^3+1, initial value 0), and a final 1. When `cmd_oe` is low, `cmd_out` is 1.
- R3: If `rsp_expect` was 0 at start, the engine goes idle right after the frame. It sets no end-of-response flag and leaves `rx_pending` at 0.
- R4: With a response expected, the wait begins in the cycle after the end bit. A 0 on `cmd_in` in any of the first 64 wait cycles starts reception. If all 64 wait cycles see 1, the engine sets `timeout` and `eor_irq`, clears `rx_pending`, and goes idle.
- R5: `rsp_long` chooses the response length: 136 bits if set, 48 bits if clear. The received bits, counted from the start bit, are pushed into the FIFO in whole bytes, MSB first. That gives 6 bytes for a short response and 17 for a long one.
- R6: When a response completes, `fmt_ok` is 1 if the last bit received was 1, and 0 otherwise.
- R7: For a short response, CRC7 covers the first 40 bits. For a long response, it covers the bits from position 8 through 127 counted from the start bit. The result is compared with the seven bits just before the end bit, and `crc_ok` shows whether they match. If `crc_skip` was set at start, `crc_ok` reads 1.
- R8: `tx_start` clears `eor_irq`, `fmt_ok`, `crc_ok`, `timeout` and the FIFO, and sets `rx_pending` to `rsp_expect`.
- R9: `eor_irq` is set when a response completes or times out, and it stays set until the next start.
- R10: While `ptr_reset` is high, the FIFO read pointer is held at the first byte and `rx_rd` has no effect. Afterwards `rx_level` again counts every stored byte and `rx_data` shows byte 0.
- R11: While `ctl_reset` is high, the engine is forced idle from the next cycle on (`busy` and `cmd_oe` are 0). It also ignores `tx_start` and resets the buffer slot pointer. The status flags keep their values.
- R12: `rx_data` shows the oldest unread byte. `rx_rd` moves on to the next byte and lowers `rx_level` by one when `rx_level` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one MMC bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command buffer write strobe |
| cmd_wdata | input | 8 | Command buffer write byte |
| rsp_expect | input | 1 | A response is expected (sampled at start) |
| rsp_long | input | 1 | Response is 136 bits (sampled at start) |
| crc_skip | input | 1 | Do not check the response CRC (sampled at start) |
| tx_start | input | 1 | Launch the buffered command |
| ctl_reset | input | 1 | Level-held engine reset |
| ptr_reset | input | 1 | Level-held FIFO read pointer rewind |
| rx_rd | input | 1 | Pop one received byte |
| rx_data | output | 8 | Oldest unread received byte |
| rx_level | output | 5 | Number of unread received bytes |
| cmd_out | output | 1 | Command line drive value |
| cmd_oe | output | 1 | Command line output enable |
| cmd_in | input | 1 | Command line input from card |
| busy | output | 1 | Engine not idle |
| rx_pending | output | 1 | Response expected and not yet finished |
| eor_irq | output | 1 | End-of-response flag and interrupt request |
| fmt_ok | output | 1 | Last response ended with a 1 bit |
| crc_ok | output | 1 | Last response CRC7 matched or was skipped |
| timeout | output | 1 | No response start within the wait window |

## Verification
A bit counter that is off shows up within one frame. `cmd_oe` then stays high for a number of cycles other than 48, or the CRC or end bit of a frame appears in the wrong bit slot. On the receive side the same error moves the byte boundaries, which changes both `rx_level` and the bytes read back. A fault in the CRC window or its taps changes `crc_ok` in the cycle after the end bit. A fault in the wait counter changes which delay, 63 or 64 cycles, still counts as a response. A wrong flag clear or set is visible at the very next start or completion.

// File: rtl/mmc_cmd_pkg.sv
package mmc_cmd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TX   = 2'd1,
        ST_WAIT = 2'd2,
        ST_RX   = 2'd3
    } eng_state_e;

    localparam int         CRC_W    = 7;
    localparam logic [6:0] CRC_TAPS = 7'h09;
    localparam int         ARG_BYTES = 4;
    localparam int         BUF_BITS  = 8 * (ARG_BYTES + 1);

endpackage

// File: rtl/mmc_crc7.sv
module mmc_crc7
    import mmc_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             din,
    output logic [CRC_W-1:0] crc
);
    logic [CRC_W-1:0] crc_d, crc_q;
    logic             fb;

    always_comb begin
        crc_d = crc_q;
        fb    = crc_q[CRC_W-1] ^ din;
        if (clr) begin
            crc_d = '0;
        end else if (en) begin
            crc_d = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? CRC_TAPS : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= '0;
        else        crc_q <= crc_d;
    end

    assign crc = crc_q;
endmodule

// File: rtl/mmc_rx_fifo.sv
module mmc_rx_fifo #(
    parameter  int DEPTH = 17,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_clr,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             rd_clr,
    input  logic             rd_en,
    output logic [7:0]       rd_data,
    output logic [LVL_W-1:0] level
);
    logic [7:0]       mem_d [DEPTH];
    logic [7:0]       mem_q [DEPTH];
    logic [LVL_W-1:0] wp_d, wp_q, rp_d, rp_q;

    always_comb begin
        mem_d = mem_q;
        wp_d  = wp_q;
        rp_d  = rp_q;
        if (wr_clr) begin
            wp_d = '0;
            rp_d = '0;
        end else begin
            if (wr_en && (wp_q < LVL_W'(DEPTH))) begin
                mem_d[wp_q] = wr_data;
                wp_d        = wp_q + 1'b1;
            end
            if (rd_clr) begin
                rp_d = '0;
            end else if (rd_en && (rp_q < wp_q)) begin
                rp_d = rp_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q <= '0;
            rp_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            wp_q  <= wp_d;
            rp_q  <= rp_d;
            mem_q <= mem_d;
        end
    end

    assign rd_data = (rp_q < LVL_W'(DEPTH)) ? mem_q[rp_q] : 8'h00;
    assign level   = wp_q - rp_q;
endmodule

// File: rtl/mmc_cmd_engine.sv
module mmc_cmd_engine
    import mmc_cmd_pkg::*;
#(
    parameter  int NCR_MAX    = 64,
    parameter  int SHORT_BITS = 48,
    parameter  int LONG_BITS  = 136,
    localparam int LVL_W      = $clog2(LONG_BITS / 8 + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [7:0]       cmd_wdata,
    input  logic             rsp_expect,
    input  logic             rsp_long,
    input  logic             crc_skip,
    input  logic             tx_start,
    input  logic             ctl_reset,
    input  logic             ptr_reset,
    input  logic             rx_rd,
    output logic [7:0]       rx_data,
    output logic [LVL_W-1:0] rx_level,
    output logic             cmd_out,
    output logic             cmd_oe,
    input  logic             cmd_in,
    output logic             busy,
    output logic             rx_pending,
    output logic             eor_irq,
    output logic             fmt_ok,
    output logic             crc_ok,
    output logic             timeout
);
    localparam int CNT_W     = $clog2(LONG_BITS);
    localparam int NCR_W     = $clog2(NCR_MAX);
    localparam int HDR_BITS  = SHORT_BITS - 8;
    localparam int LONG_SKIP = 8;
    localparam int FIFO_D    = LONG_BITS / 8;
    localparam int SLOT_LAST = ARG_BYTES;

    typedef struct packed {
        eng_state_e          st;
        logic [BUF_BITS-1:0] cbuf;
        logic [2:0]          slot;
        logic [BUF_BITS-1:0] tx_sr;
        logic [CNT_W-1:0]    bit_ix;
        logic [NCR_W-1:0]    ncr;
        logic [7:0]          rx_byte;
        logic                exp_rsp;
        logic                long_rsp;
        logic                no_crc;
        logic                rx_pend;
        logic                eor;
        logic                fmt;
        logic                crc;
        logic                tmo;
    } regs_t;

    regs_t r_d, r_q;

    logic             tx_crc_clr, tx_crc_en;
    logic             rx_crc_clr, rx_crc_en;
    logic [CRC_W-1:0] tx_crc, rx_crc;
    logic             fifo_clr, fifo_push;
    logic [7:0]       fifo_byte;
    logic             tx_bit;
    logic [2:0]       crc_sel;
    logic [CNT_W-1:0] rsp_len;

    // Bit presented on the line during transmit
    always_comb begin
        crc_sel = 3'(r_q.bit_ix - CNT_W'(HDR_BITS));
        if (r_q.bit_ix < CNT_W'(HDR_BITS)) begin
            tx_bit = r_q.tx_sr[BUF_BITS-1];
        end else if (r_q.bit_ix < CNT_W'(SHORT_BITS - 1)) begin
            tx_bit = tx_crc[3'd6 - crc_sel];
        end else begin
            tx_bit = 1'b1;
        end
    end

    always_comb begin
        r_d        = r_q;
        tx_crc_clr = 1'b0;
        tx_crc_en  = 1'b0;
        rx_crc_clr = 1'b0;
        rx_crc_en  = 1'b0;
        fifo_clr   = 1'b0;
        fifo_push  = 1'b0;
        fifo_byte  = {r_q.rx_byte[6:0], cmd_in};
        rsp_len    = r_q.long_rsp ? CNT_W'(LONG_BITS) : CNT_W'(SHORT_BITS);

        unique case (r_q.st)
            ST_IDLE: begin
                if (tx_start) begin
                    r_d.st       = ST_TX;
                    r_d.tx_sr    = r_q.cbuf;
                    r_d.bit_ix   = '0;
                    r_d.slot     = '0;
                    r_d.exp_rsp  = rsp_expect;
                    r_d.long_rsp = rsp_long;
                    r_d.no_crc   = crc_skip;
                    r_d.rx_pend  = rsp_expect;
                    r_d.eor      = 1'b0;
                    r_d.fmt      = 1'b0;
                    r_d.crc      = 1'b0;
                    r_d.tmo      = 1'b0;
                    tx_crc_clr   = 1'b1;
                    rx_crc_clr   = 1'b1;
                    fifo_clr     = 1'b1;
                end else if (cmd_wr) begin
                    if (r_q.slot == 3'd0) begin
                        r_d.cbuf[BUF_BITS-1 -: 8] = {2'b01, cmd_wdata[5:0]};
                    end else begin
                        r_d.cbuf[8 * (SLOT_LAST - int'(r_q.slot)) +: 8] = cmd_wdata;
                    end
                    r_d.slot = (r_q.slot == 3'(SLOT_LAST)) ? 3'd0 : r_q.slot + 3'd1;
                end
            end

            ST_TX: begin
                if (r_q.bit_ix < CNT_W'(HDR_BITS)) begin
                    tx_crc_en = 1'b1;
                    r_d.tx_sr = {r_q.tx_sr[BUF_BITS-2:0], 1'b0};
                end
                if (r_q.bit_ix == CNT_W'(SHORT_BITS - 1)) begin
                    r_d.bit_ix = '0;
                    r_d.ncr    = '0;
                    r_d.st     = r_q.exp_rsp ? ST_WAIT : ST_IDLE;
                end else begin
                    r_d.bit_ix = r_q.bit_ix + 1'b1;
                end
            end

            ST_WAIT: begin
                if (!cmd_in) begin
                    r_d.st      = ST_RX;
                    r_d.bit_ix  = CNT_W'(1);
                    r_d.rx_byte = 8'h00;
                    rx_crc_en   = !r_q.long_rsp;
                end else if (r_q.ncr == NCR_W'(NCR_MAX - 1)) begin
                    r_d.st      = ST_IDLE;
                    r_d.tmo     = 1'b1;
                    r_d.eor     = 1'b1;
                    r_d.rx_pend = 1'b0;
                end else begin
                    r_d.ncr = r_q.ncr + 1'b1;
                end
            end

            ST_RX: begin
                r_d.rx_byte = fifo_byte;
                if ((r_q.bit_ix < rsp_len - CNT_W'(8)) &&
                    (!r_q.long_rsp || r_q.bit_ix >= CNT_W'(LONG_SKIP))) begin
                    rx_crc_en = 1'b1;
                end
                if (r_q.bit_ix[2:0] == 3'd7) begin
                    fifo_push = 1'b1;
                end
                if (r_q.bit_ix == rsp_len - 1'b1) begin
                    r_d.st      = ST_IDLE;
                    r_d.fmt     = cmd_in;
                    r_d.crc     = r_q.no_crc || (r_q.rx_byte[6:0] == rx_crc);
                    r_d.eor     = 1'b1;
                    r_d.rx_pend = 1'b0;
                    r_d.bit_ix  = '0;
                end else begin
                    r_d.bit_ix = r_q.bit_ix + 1'b1;
                end
            end

            default: r_d.st = ST_IDLE;
        endcase

        if (ctl_reset) begin
            r_d.st      = ST_IDLE;
            r_d.slot    = '0;
            r_d.bit_ix  = '0;
            r_d.ncr     = '0;
            r_d.rx_pend = 1'b0;
            r_d.cbuf    = r_q.cbuf;
            tx_crc_clr  = 1'b0;
            rx_crc_clr  = 1'b0;
            fifo_clr    = 1'b0;
            fifo_push   = 1'b0;
            tx_crc_en   = 1'b0;
            rx_crc_en   = 1'b0;
            r_d.eor     = r_q.eor;
            r_d.fmt     = r_q.fmt;
            r_d.crc     = r_q.crc;
            r_d.tmo     = r_q.tmo;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    mmc_crc7 u_tx_crc (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (tx_crc_clr),
        .en   (tx_crc_en),
        .din  (r_q.tx_sr[BUF_BITS-1]),
        .crc  (tx_crc)
    );

    mmc_crc7 u_rx_crc (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (rx_crc_clr),
        .en   (rx_crc_en),
        .din  (cmd_in),
        .crc  (rx_crc)
    );

    mmc_rx_fifo #(.DEPTH(FIFO_D)) u_fifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_clr (fifo_clr),
        .wr_en  (fifo_push),
        .wr_data(fifo_byte),
        .rd_clr (ptr_reset),
        .rd_en  (rx_rd),
        .rd_data(rx_data),
        .level  (rx_level)
    );

    assign cmd_oe     = (r_q.st == ST_TX);
    assign cmd_out    = (r_q.st == ST_TX) ? tx_bit : 1'b1;
    assign busy       = (r_q.st != ST_IDLE);
    assign rx_pending = r_q.rx_pend;
    assign eor_irq    = r_q.eor;
    assign fmt_ok     = r_q.fmt;
    assign crc_ok     = r_q.crc;
    assign timeout    = r_q.tmo;
endmodule

// File: rtl/mmc_cmd_engine_chk.sv
module mmc_cmd_engine_chk #(
    parameter int FRAME_LEN = 48,
    parameter int MAX_LVL   = 17,
    parameter int LVL_W     = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_reset,
    input logic             cmd_oe,
    input logic             cmd_out,
    input logic             busy,
    input logic             rx_pending,
    input logic             eor_irq,
    input logic             crc_ok,
    input logic             fmt_ok,
    input logic             timeout,
    input logic [LVL_W-1:0] rx_level
);
    logic [7:0] oe_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      oe_run <= '0;
        else if (cmd_oe) oe_run <= oe_run + 8'd1;
        else             oe_run <= '0;
    end

    AST_FRAME_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cmd_oe) && !$past(ctl_reset)) |-> (oe_run == 8'(FRAME_LEN))); // R2
    AST_LINE_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_oe |-> cmd_out); // R2
    AST_DRIVE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_oe |-> busy); // R11
    AST_START_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (!eor_irq && !crc_ok && !fmt_ok && !timeout)); // R8
    AST_EOR_ENDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eor_irq) |-> (!rx_pending && !busy)); // R9
    AST_TIMEOUT_RAISES_EOR: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> eor_irq); // R4
    AST_CTL_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_reset |=> (!busy && !cmd_oe)); // R11
    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rx_level <= LVL_W'(MAX_LVL)); // R5
endmodule

bind mmc_cmd_engine mmc_cmd_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_reset (ctl_reset),
    .cmd_oe    (cmd_oe),
    .cmd_out   (cmd_out),
    .busy      (busy),
    .rx_pending(rx_pending),
    .eor_irq   (eor_irq),
    .crc_ok    (crc_ok),
    .fmt_ok    (fmt_ok),
    .timeout   (timeout),
    .rx_level  (rx_level)
);

// File: tb/mmc_cmd_engine_test.sv
`timescale 1ns/1ps
module mmc_cmd_engine_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_wr = 1'b0;
    logic [7:0] cmd_wdata = 8'h00;
    logic       rsp_expect = 1'b0, rsp_long = 1'b0, crc_skip = 1'b0;
    logic       tx_start = 1'b0, ctl_reset = 1'b0, ptr_reset = 1'b0, rx_rd = 1'b0;
    logic [7:0] rx_data;
    logic [4:0] rx_level;
    logic       cmd_out, cmd_oe, cmd_in = 1'b1;
    logic       busy, rx_pending, eor_irq, fmt_ok, crc_ok, timeout;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    mmc_cmd_engine uut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .rsp_expect(rsp_expect), .rsp_long(rsp_long), .crc_skip(crc_skip),
        .tx_start(tx_start), .ctl_reset(ctl_reset), .ptr_reset(ptr_reset),
        .rx_rd(rx_rd), .rx_data(rx_data), .rx_level(rx_level),
        .cmd_out(cmd_out), .cmd_oe(cmd_oe), .cmd_in(cmd_in),
        .busy(busy), .rx_pending(rx_pending), .eor_irq(eor_irq),
        .fmt_ok(fmt_ok), .crc_ok(crc_ok), .timeout(timeout)
    );

    typedef struct packed {
        logic [5:0]  idx;
        logic [31:0] arg;
        logic        lng;
        logic [6:0]  dly;
        logic        bad_crc;
        logic        bad_end;
        logic        skip;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{6'd0,  32'h0000_0000, 1'b0, 7'd2,  1'b0, 1'b0, 1'b0},
        '{6'd17, 32'h0000_1234, 1'b0, 7'd0,  1'b0, 1'b0, 1'b0},
        '{6'd2,  32'h0000_0000, 1'b1, 7'd5,  1'b0, 1'b0, 1'b0},
        '{6'd13, 32'hDEAD_BEEF, 1'b0, 7'd63, 1'b1, 1'b0, 1'b0},
        '{6'd9,  32'h8765_4321, 1'b1, 7'd1,  1'b0, 1'b1, 1'b0},
        '{6'd55, 32'h0F0F_A5A5, 1'b0, 7'd3,  1'b1, 1'b0, 1'b1}
    };

    function automatic logic [6:0] ref_crc(input logic [127:0] v, input int n);
        logic [6:0] c = 7'h00;
        for (int i = n - 1; i >= 0; i--) begin
            logic top = c[6] ^ v[i];
            c = {c[5:0], 1'b0};
            if (top) begin
                c[3] = ~c[3];
                c[0] = ~c[0];
            end
        end
        return c;
    endfunction

    function automatic logic [47:0] ref_frame(input logic [5:0] idx, input logic [31:0] arg);
        logic [39:0] hdr = {2'b01, idx, arg};
        return {hdr, ref_crc({88'b0, hdr}, 40), 1'b1};
    endfunction

    function automatic logic [135:0] ref_resp(input vec_t t);
        logic [135:0] r;
        logic [119:0] pay;
        if (t.lng) begin
            for (int j = 0; j < 15; j++)
                pay[119 - 8*j -: 8] = t.arg[8*(j%4) +: 8] ^ 8'(j * 17);
            r = {8'h3F, pay, ref_crc({8'b0, pay}, 120), 1'b1};
        end else begin
            r = {88'b0, 2'b00, t.idx, t.arg, ref_crc({88'b0, 2'b00, t.idx, t.arg}, 40), 1'b1};
        end
        if (t.bad_crc) r[1] = ~r[1];
        if (t.bad_end) r[0] = 1'b0;
        return r;
    endfunction

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic load_cmd(input logic [5:0] idx, input logic [31:0] arg);
        for (int b = 0; b < 5; b++) begin
            cmd_wr    = 1'b1;
            cmd_wdata = (b == 0) ? {2'b00, idx} : arg[8*(4-b) +: 8];
            @(negedge clk);
        end
        cmd_wr = 1'b0;
    endtask

    task automatic send_cmd(input logic ex, input logic lg, input logic sk,
                            output logic [47:0] fr, output int oe_cnt);
        rsp_expect = ex; rsp_long = lg; crc_skip = sk;
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
        oe_cnt = 0;
        for (int k = 0; k < 48; k++) begin
            fr[47 - k] = cmd_out;
            if (cmd_oe) oe_cnt++;
            @(negedge clk);
        end
    endtask

    task automatic drive_resp(input int dly, input logic [135:0] r, input int len);
        for (int d = 0; d < dly; d++) begin
            cmd_in = 1'b1;
            @(negedge clk);
        end
        for (int j = 0; j < len; j++) begin
            cmd_in = r[len - 1 - j];
            @(negedge clk);
        end
        cmd_in = 1'b1;
    endtask

    logic [47:0]  frame;
    logic [135:0] resp;
    int           oe_n, len, nb;
    vec_t         t;

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        chk(!busy && !cmd_oe && cmd_out, "R2 reset line idle", {busy, cmd_oe, cmd_out}, 3'b001);
        chk(!eor_irq && !timeout && rx_level == 0, "R9 reset flags", {eor_irq, timeout, rx_level}, 0);

        // Table-driven commands with responses
        for (int v = 0; v < NVEC; v++) begin
            t    = VECS[v];
            len  = t.lng ? 136 : 48;
            nb   = len / 8;
            resp = ref_resp(t);
            load_cmd(t.idx, t.arg);
            send_cmd(1'b1, t.lng, t.skip, frame, oe_n);
            chk(frame == ref_frame(t.idx, t.arg), "R2 frame bits", frame, ref_frame(t.idx, t.arg));
            chk(oe_n == 48, "R2 drive length", oe_n, 48);
            if (v == 0) chk(frame == 48'h40_0000_0000_95, "R2 known CRC", frame, 48'h40_0000_0000_95);
            chk(rx_pending && busy && !eor_irq, "R8 pending after start", {rx_pending, busy, eor_irq}, 3'b110);
            drive_resp(t.dly, resp, len);
            chk(eor_irq && !busy && !rx_pending && !timeout, "R9 end of response",
                {eor_irq, busy, rx_pending, timeout}, 4'b1000);
            chk(fmt_ok == !t.bad_end, "R6 format status", fmt_ok, !t.bad_end);
            chk(crc_ok == (t.skip || !t.bad_crc), "R7 crc status", crc_ok, t.skip || !t.bad_crc);
            chk(rx_level == 5'(nb), "R5 byte count", rx_level, nb);
            if (v == 0) begin
                // R12 read two, then R10 rewind with a read attempt held off
                for (int k = 0; k < 2; k++) begin
                    rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;
                end
                chk(rx_level == 5'(nb - 2), "R12 level after reads", rx_level, nb - 2);
                ptr_reset = 1'b1; rx_rd = 1'b1;
                @(negedge clk);
                @(negedge clk);
                ptr_reset = 1'b0; rx_rd = 1'b0;
                @(negedge clk);
                chk(rx_level == 5'(nb) && rx_data == resp[47 -: 8], "R10 pointer rewind",
                    {rx_level, rx_data}, {5'(nb), resp[47 -: 8]});
            end
            for (int k = 0; k < nb; k++) begin
                chk(rx_data == resp[len - 1 - 8*k -: 8], "R5 R12 response byte",
                    rx_data, resp[len - 1 - 8*k -: 8]);
                rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;
            end
            chk(rx_level == 0, "R12 drained", rx_level, 0);
        end

        // R8 start clears the flags left by the last vector
        load_cmd(6'd1, 32'h0000_00FF);
        send_cmd(1'b1, 1'b0, 1'b0, frame, oe_n);
        chk(!eor_irq && !crc_ok && !fmt_ok && rx_level == 0, "R8 flags cleared",
            {eor_irq, crc_ok, fmt_ok, rx_level}, 0);
        // R4 silent card: 64 wait cycles of 1 give a timeout
        drive_resp(64, 136'h0, 0);
        chk(timeout && eor_irq && !busy && !rx_pending, "R4 timeout",
            {timeout, eor_irq, busy, rx_pending}, 4'b1100);

        // R3 no response expected
        send_cmd(1'b0, 1'b0, 1'b0, frame, oe_n);
        chk(!busy && !eor_irq && !rx_pending && !timeout, "R3 no response",
            {busy, eor_irq, rx_pending, timeout}, 0);
        chk(frame == ref_frame(6'd1, 32'h0000_00FF), "R2 resend from buffer", frame,
            ref_frame(6'd1, 32'h0000_00FF));

        // R1 slot pointer wraps after the fifth write
        load_cmd(6'd3, 32'h1122_3344);
        cmd_wr = 1'b1; cmd_wdata = 8'hC5; @(negedge clk);
        cmd_wdata = 8'h99; @(negedge clk);
        cmd_wr = 1'b0;
        send_cmd(1'b0, 1'b0, 1'b0, frame, oe_n);
        chk(frame == ref_frame(6'd5, 32'h9922_3344), "R1 slot wrap", frame,
            ref_frame(6'd5, 32'h9922_3344));

        // R11 engine reset during the wait; start held off while reset is high
        load_cmd(6'd7, 32'h0);
        send_cmd(1'b1, 1'b0, 1'b0, frame, oe_n);
        @(negedge clk);
        ctl_reset = 1'b1; tx_start = 1'b1;
        @(negedge clk);
        chk(!busy && !cmd_oe && !rx_pending, "R11 forced idle", {busy, cmd_oe, rx_pending}, 0);
        @(negedge clk);
        chk(!busy && !cmd_oe, "R11 start ignored", {busy, cmd_oe}, 0);
        ctl_reset = 1'b0; tx_start = 1'b0;
        @(negedge clk);
        chk(!busy && !eor_irq, "R11 stays idle", {busy, eor_irq}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule